// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block sits between a processor's load/store port and a small local word memory. It tracks whether the processor holds an exclusive reservation, and it decides whether each store-exclusive may write memory. A load-exclusive reads the addressed value and records its byte address and access size as the reservation. A later store-exclusive writes only when that reservation is still held and matches the address and size exactly. Each store-exclusive returns a one-bit status, where 0 means the write happened and 1 means nothing was written.

The reservation is removed by every store-exclusive, whether it succeeds or fails. An explicit clear request also removes it, and so does an exception-entry pulse. Software can therefore build retry loops for read-modify-write updates and for claiming a semaphore. Ordinary loads and stores go straight through to memory and leave the reservation as it is. Byte and halfword stores write only the addressed lanes of the 32-bit word, with little-endian lane selection.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor holds no reservation, `wr_en`, `rd_valid` and `sts_valid` are low, and the first store-exclusive returns status 1 without writing.
- R2: A load-exclusive returns the addressed value on `rd_data` with `rd_valid` high one cycle after the request, zero-extended to its size, and it takes a reservation on that address and size.
- R3: A store-exclusive whose address and size equal the held reservation raises `wr_en` in its request cycle, writes memory, and returns `sts_fail` = 0 with `sts_valid` one cycle later.
- R4: A store-exclusive without a held reservation keeps `wr_en` low, leaves memory unchanged, and returns `sts_fail` = 1.
- R5: Every store-exclusive removes the reservation, so a second store-exclusive that follows at once fails.
- R6: A clear request (op 4) removes the reservation and never writes memory.
- R7: Exception entry removes the reservation even when no request is present. When it arrives in the same cycle as a store-exclusive, that store fails and writes nothing.
- R8: A store-exclusive whose byte address or size differs from the reservation fails with status 1.
- R9: A new load-exclusive replaces the reservation with its own address and size.
- R10: Size codes are 0 = byte, 1 = halfword and 2 = word. Write data is taken from the low bits. A byte goes to lane addr[1:0], a halfword goes to bytes 2..3 when addr[1] is 1 and to bytes 0..1 otherwise, and other bytes stay unchanged.
- R11: Op codes are 0 = load, 1 = store, 2 = load-exclusive, 3 = store-exclusive and 4 = clear. Plain loads and stores access memory directly and neither take nor drop the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R11) |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size (see R10) |
| req_wdata | input | 32 | Store data, right-justified |
| exc_entry | input | 1 | Exception-entry pulse |
| wr_en | output | 1 | Memory write enable for this cycle's request |
| rd_valid | output | 1 | Load data valid (one cycle after a load) |
| rd_data | output | 32 | Zero-extended load data |
| sts_valid | output | 1 | Store-exclusive status valid |
| sts_fail | output | 1 | Store-exclusive status: 1 = failed, no write |

## Verification
The bench builds the block with ADDR_W = 5, which gives a memory of eight words. With so few addresses, random load-exclusive and store-exclusive requests often land on the same byte address and size, so successful stores occur frequently alongside near-miss failures on size or address. Directed sequences cover a read-modify-write retry, a semaphore claim, an exception that arrives in the same cycle as a store, and byte and halfword lane writes.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              exc_entry,
  output logic              wr_en,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              sts_valid,
  output logic              sts_fail
);
  localparam int WORDS = 1 << (ADDR_W - 2);
  localparam logic [2:0] OP_LD  = 3'd0;
  localparam logic [2:0] OP_ST  = 3'd1;
  localparam logic [2:0] OP_LDX = 3'd2;
  localparam logic [2:0] OP_STX = 3'd3;
  localparam logic [2:0] OP_CLR = 3'd4;

  logic              tag_q;
  logic [ADDR_W-1:0] tag_addr_q;
  logic [1:0]        tag_size_q;
  logic [31:0]       mem [WORDS];

  wire is_ld  = req_valid && (req_op == OP_LD || req_op == OP_LDX);
  wire is_st  = req_valid && (req_op == OP_ST);
  wire is_ldx = req_valid && (req_op == OP_LDX);
  wire is_stx = req_valid && (req_op == OP_STX);
  wire is_clr = req_valid && (req_op == OP_CLR);

  wire stx_hit = is_stx && tag_q && !exc_entry &&
                 (tag_addr_q == req_addr) && (tag_size_q == req_size);

  assign wr_en = is_st || stx_hit;

  wire [ADDR_W-3:0] widx = req_addr[ADDR_W-1:2];
  wire [1:0]        lane = req_addr[1:0];

  logic [3:0]  be;
  logic [31:0] wrep;
  always_comb begin
    case (req_size)
      2'd0:    begin be = 4'b0001 << lane;                       wrep = {4{req_wdata[7:0]}};  end
      2'd1:    begin be = req_addr[1] ? 4'b1100 : 4'b0011;       wrep = {2{req_wdata[15:0]}}; end
      default: begin be = 4'b1111;                               wrep = req_wdata;            end
    endcase
  end

  wire [31:0] rword  = mem[widx];
  wire [31:0] rshift = rword >> {lane, 3'b000};
  logic [31:0] rext;
  always_comb begin
    case (req_size)
      2'd0:    rext = {24'd0, rshift[7:0]};
      2'd1:    rext = {16'd0, rshift[15:0]};
      default: rext = rword;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) mem[widx][8*b +: 8] <= wrep[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q      <= 1'b0;
      tag_addr_q <= '0;
      tag_size_q <= '0;
    end else if (exc_entry || is_stx || is_clr) begin
      tag_q      <= 1'b0;
    end else if (is_ldx) begin
      tag_q      <= 1'b1;
      tag_addr_q <= req_addr;
      tag_size_q <= req_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      sts_valid <= 1'b0;
      sts_fail  <= 1'b0;
    end else begin
      rd_valid  <= is_ld;
      rd_data   <= is_ld ? rext : '0;
      sts_valid <= is_stx;
      sts_fail  <= is_stx && !stx_hit;
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              exc_entry,
  input logic              wr_en,
  input logic              rd_valid,
  input logic              sts_valid,
  input logic              sts_fail,
  input logic              tag_q
);
  AST_RESET_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tag_q && !sts_valid && !rd_valid)); // R1
  AST_LDX_TAKES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && !exc_entry) |=> tag_q); // R2
  AST_STATUS_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> (sts_fail == !$past(wr_en))); // R3
  AST_NO_TAG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3 && !tag_q) |-> !wr_en); // R4
  AST_STX_DROPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3) |=> (!tag_q && sts_valid)); // R5
  AST_CLEAR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |-> !wr_en ##1 !tag_q); // R6
  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |-> (!(req_valid && req_op == 3'd3) || !wr_en) ##1 !tag_q); // R7
  AST_LOADS_NEVER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 3'd0 || req_op == 3'd2)) |-> !wr_en); // R11
  AST_PLAIN_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op <= 3'd1 && !exc_entry) |=> (tag_q == $past(tag_q))); // R11

  wire unused_ok = ^{req_addr, req_size};
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .req_size(req_size), .exc_entry(exc_entry),
  .wr_en(wr_en), .rd_valid(rd_valid), .sts_valid(sts_valid),
  .sts_fail(sts_fail), .tag_q(tag_q)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
  localparam int AW = 5;
  localparam int NW = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [31:0]   req_wdata = '0;
  logic          exc_entry = 1'b0;
  logic          wr_en, rd_valid, sts_valid, sts_fail;
  logic [31:0]   rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0]   m_mem [NW];
  bit            m_tag;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_size;

  always #2.5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .exc_entry(exc_entry), .wr_en(wr_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .sts_valid(sts_valid), .sts_fail(sts_fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_read(input logic [31:0] w, input logic [1:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return (w >> (8 * a)) & 32'hFF;
      2'd1:    return a[1] ? {16'd0, w[31:16]} : {16'd0, w[15:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] f_merge(input logic [31:0] w, input logic [1:0] a,
                                          input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r = w;
    case (sz)
      2'd0: r[8*a +: 8] = d[7:0];
      2'd1: if (a[1]) r[31:16] = d[15:0]; else r[15:0] = d[15:0];
      default: r = d;
    endcase
    return r;
  endfunction

  task automatic op(input bit v, input logic [2:0] o, input logic [AW-1:0] a,
                    input logic [1:0] sz, input logic [31:0] d, input bit exc,
                    input string req);
    bit hit, exp_we;
    logic [31:0] exp_rd;
    int wi;
    @(negedge clk);
    req_valid = v; req_op = o; req_addr = a; req_size = sz; req_wdata = d; exc_entry = exc;
    #1;
    wi = int'(a[AW-1:2]);
    hit = v && o == 3'd3 && m_tag && a == m_addr && sz == m_size && !exc;
    exp_we = (v && o == 3'd1) || hit;
    exp_rd = f_read(m_mem[wi], a[1:0], sz);
    chk(wr_en == exp_we, req, "wr_en", {31'd0, wr_en}, {31'd0, exp_we});
    if (exp_we) m_mem[wi] = f_merge(m_mem[wi], a[1:0], sz, d);
    if (exc || (v && (o == 3'd3 || o == 3'd4))) m_tag = 0;
    else if (v && o == 3'd2) begin m_tag = 1; m_addr = a; m_size = sz; end
    @(posedge clk);
    #1;
    req_valid = 0; exc_entry = 0;
    if (v && (o == 3'd0 || o == 3'd2)) begin
      chk(rd_valid == 1'b1, req, "rd_valid", {31'd0, rd_valid}, 32'd1);
      chk(rd_data == exp_rd, req, "rd_data", rd_data, exp_rd);
    end
    if (v && o == 3'd3) begin
      chk(sts_valid == 1'b1, req, "sts_valid", {31'd0, sts_valid}, 32'd1);
      chk(sts_fail == !hit, req, "sts_fail", {31'd0, sts_fail}, {31'd0, !hit});
    end else begin
      chk(sts_valid == 1'b0, req, "sts_valid idle", {31'd0, sts_valid}, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NW; i++) m_mem[i] = '0;
    m_tag = 0; m_addr = '0; m_size = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!wr_en && !rd_valid && !sts_valid, "R1", "reset outputs",
        {29'd0, wr_en, rd_valid, sts_valid}, 32'd0);
    @(negedge clk); rst_n = 1;

    op(1, 3'd3, 5'd0, 2'd2, 32'hDEAD_BEEF, 0, "R1");
    op(1, 3'd0, 5'd0, 2'd2, 0, 0, "R4");

    op(1, 3'd1, 5'd4, 2'd2, 32'h0000_0010, 0, "R11");
    op(1, 3'd2, 5'd4, 2'd2, 0, 0, "R2");
    op(1, 3'd3, 5'd4, 2'd2, 32'h0000_0011, 0, "R3");
    op(1, 3'd3, 5'd4, 2'd2, 32'h0000_0099, 0, "R5");
    op(1, 3'd0, 5'd4, 2'd2, 0, 0, "R5");

    op(1, 3'd2, 5'd4, 2'd2, 0, 0, "R6");
    op(1, 3'd4, 5'd4, 2'd2, 32'hFFFF_FFFF, 0, "R6");
    op(1, 3'd3, 5'd4, 2'd2, 32'h0000_0077, 0, "R6");

    op(1, 3'd2, 5'd8, 2'd2, 0, 0, "R7");
    op(0, 3'd0, 5'd0, 2'd0, 0, 1, "R7");
    op(1, 3'd3, 5'd8, 2'd2, 32'h1234_5678, 0, "R7");
    op(1, 3'd2, 5'd8, 2'd2, 0, 0, "R7");
    op(1, 3'd3, 5'd8, 2'd2, 32'h1234_5678, 1, "R7");
    op(1, 3'd0, 5'd8, 2'd2, 0, 0, "R7");

    op(1, 3'd2, 5'd9, 2'd0, 0, 0, "R8");
    op(1, 3'd3, 5'd8, 2'd1, 32'hAAAA, 0, "R8");
    op(1, 3'd2, 5'd9, 2'd0, 0, 0, "R8");
    op(1, 3'd3, 5'd10, 2'd0, 32'hBB, 0, "R8");

    op(1, 3'd2, 5'd0, 2'd2, 0, 0, "R9");
    op(1, 3'd2, 5'd4, 2'd2, 0, 0, "R9");
    op(1, 3'd3, 5'd0, 2'd2, 32'h5555_5555, 0, "R9");
    op(1, 3'd2, 5'd0, 2'd2, 0, 0, "R9");
    op(1, 3'd2, 5'd4, 2'd2, 0, 0, "R9");
    op(1, 3'd3, 5'd4, 2'd2, 32'h6666_6666, 0, "R9");

    op(1, 3'd1, 5'd12, 2'd2, 32'h0, 0, "R10");
    op(1, 3'd2, 5'd14, 2'd0, 0, 0, "R10");
    op(1, 3'd3, 5'd14, 2'd0, 32'hFFFF_FFAB, 0, "R10");
    op(1, 3'd2, 5'd14, 2'd1, 0, 0, "R10");
    op(1, 3'd2, 5'd12, 2'd1, 0, 0, "R10");
    op(1, 3'd3, 5'd12, 2'd1, 32'h1111_C0DE, 0, "R10");
    op(1, 3'd0, 5'd12, 2'd2, 0, 0, "R10");

    op(1, 3'd2, 5'd16, 2'd2, 0, 0, "R11");
    op(1, 3'd1, 5'd20, 2'd2, 32'h0BAD_F00D, 0, "R11");
    op(1, 3'd0, 5'd20, 2'd2, 0, 0, "R11");
    op(1, 3'd3, 5'd16, 2'd2, 32'h0000_0001, 0, "R11");

    op(1, 3'd2, 5'd24, 2'd2, 0, 0, "R3");
    op(1, 3'd3, 5'd24, 2'd2, 32'h1, 0, "R3");
    op(1, 3'd2, 5'd24, 2'd2, 0, 0, "R2");

    for (int n = 0; n < 600; n++) begin
      logic [2:0] o;
      logic [1:0] sz;
      logic [AW-1:0] a;
      int r = int'($urandom % 10);
      o  = (r < 3) ? 3'd2 : (r < 6) ? 3'd3 : (r < 7) ? 3'd4 : (r < 8) ? 3'd1 : 3'd0;
      sz = 2'($urandom % 3);
      a  = AW'($urandom % 8) << sz;
      op(1, o, a, sz, $urandom, ($urandom % 16) == 0, "R3");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule